// File: doc/BRIEF.md
# Hot-Plug Line Event Classifier

This block watches the active-high hot-plug wire that a display sink drives toward its source. It turns activity on that wire into three kinds of event: a sink arriving (connect), a sink leaving (disconnect), and a short low pulse that the sink uses to request service (interrupt). Each event is reported as a single-cycle strobe. A registered flag shows whether a sink is currently considered present.

The raw wire passes through a two-flop synchronizer. All timing is then measured in microsecond ticks, which a parameterized prescaler derives from the system clock. A connection is declared only after the wire has stayed high for a long debounce window. While connected, the block measures the length of each low excursion. Very short dips are treated as noise and ignored. Medium-length pulses become interrupt requests. A low level that lasts to the disconnect threshold ends the connection, and the block then waits for the wire to rise again.

Every interrupt and every connect starts a service deadline. The host must answer it by pulsing an acknowledge once it has read the sink's status. If the deadline runs out before that acknowledge arrives, a sticky missed flag is raised.

Top module: `hpd_event_top`

## Requirements
- R1: After reset, `connected_o`, `missed_o` and all three strobes are 0, and the block treats the sink as absent.
- R2: All durations are counted in microsecond ticks. One tick lasts `CLK_PER_US` clock cycles and is measured on the wire after a two-flop synchronizer.
- R3: While disconnected, `connect_o` pulses and `connected_o` rises only after the wire has been high for `DEBOUNCE_US` ticks without a break. Any low sample before that point restarts the count from zero.
- R4: While connected, a low excursion that ends before `IRQ_MIN_US` ticks produces no strobe and leaves `connected_o` at 1.
- R5: While connected, a low excursion that ends after at least `IRQ_MIN_US` ticks but before `DISC_US` ticks pulses `irq_o` when the wire returns high, and `connected_o` stays 1.
- R6: While connected, a low level that reaches `DISC_US` ticks pulses `disconnect_o` and clears `connected_o`. The block then applies R3 again, so a later re-plug produces a fresh `connect_o`.
- R7: Each strobe lasts exactly one cycle, and at most one of `connect_o`, `disconnect_o`, `irq_o` is high in any cycle.
- R8: Each `connect_o` or `irq_o` starts a service timer from zero. If `DEADLINE_US` ticks pass without `ack_i`, `missed_o` is set and stays set.
- R9: A one-cycle `ack_i` stops the service timer and clears `missed_o` on the next cycle.
- R10: A `disconnect_o` cancels a running service timer, so `missed_o` is not raised for that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_i | input | 1 | Raw hot-plug wire from the sink (asynchronous) |
| ack_i | input | 1 | Host acknowledges that the sink status was read |
| connect_o | output | 1 | One-cycle strobe: connection confirmed |
| disconnect_o | output | 1 | One-cycle strobe: sink removed |
| irq_o | output | 1 | One-cycle strobe: interrupt pulse seen |
| connected_o | output | 1 | Sink currently considered present |
| missed_o | output | 1 | Service deadline expired without acknowledge |

## Verification
The bench first breaks a high period partway through the debounce window. A design that failed to restart its debounce count would then report a connect too early. It also sends a dip far below the interrupt minimum. A design without the glitch filter would emit a spurious interrupt for it, and the scoreboard would catch that as an unexpected event. A long low level must produce one disconnect strobe and no interrupt strobe when the wire later rises. A plug-in that follows must produce a new connect. For the deadline, the bench covers three cases: no acknowledge, so the flag must rise; an early acknowledge, so the flag must stay low; and a disconnect during a pending deadline, where a design that kept the timer running would raise a false miss.

// File: rtl/hpd_event_pkg.sv
package hpd_event_pkg;
  typedef enum logic [1:0] {
    ST_ABSENT = 2'd0,
    ST_HIGH   = 2'd1,
    ST_LOW    = 2'd2
  } line_state_t;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/hpd_tick.sv
module hpd_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + PW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/hpd_classifier.sv
module hpd_classifier
  import hpd_event_pkg::*;
#(
  parameter int IRQ_MIN_US  = 250,
  parameter int DISC_US     = 2000,
  parameter int DEBOUNCE_US = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic tick,
  output logic connect_o,
  output logic disconnect_o,
  output logic irq_o,
  output logic connected_o
);
  localparam int CW = $clog2(max3(IRQ_MIN_US, DISC_US, DEBOUNCE_US) + 1);
  localparam logic [CW-1:0] MIN_LIM = CW'(IRQ_MIN_US);
  localparam logic [CW-1:0] DSC_LIM = CW'(DISC_US);
  localparam logic [CW-1:0] DB_LIM  = CW'(DEBOUNCE_US);

  line_state_t   state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_ABSENT;
      cnt          <= '0;
      connect_o    <= 1'b0;
      disconnect_o <= 1'b0;
      irq_o        <= 1'b0;
      connected_o  <= 1'b0;
    end else begin
      connect_o    <= 1'b0;
      disconnect_o <= 1'b0;
      irq_o        <= 1'b0;
      unique case (state)
        ST_ABSENT: begin
          if (!line) begin
            cnt <= '0;
          end else if (tick) begin
            if (cnt_nx >= DB_LIM) begin
              connect_o   <= 1'b1;
              connected_o <= 1'b1;
              cnt         <= '0;
              state       <= ST_HIGH;
            end else begin
              cnt <= cnt_nx;
            end
          end
        end
        ST_HIGH: begin
          if (!line) begin
            cnt   <= '0;
            state <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (line) begin
            if (cnt >= MIN_LIM) irq_o <= 1'b1;
            cnt   <= '0;
            state <= ST_HIGH;
          end else if (tick) begin
            if (cnt_nx >= DSC_LIM) begin
              disconnect_o <= 1'b1;
              connected_o  <= 1'b0;
              cnt          <= '0;
              state        <= ST_ABSENT;
            end else begin
              cnt <= cnt_nx;
            end
          end
        end
        default: begin
          cnt   <= '0;
          state <= ST_ABSENT;
        end
      endcase
    end
  end
endmodule

// File: rtl/hpd_deadline.sv
module hpd_deadline #(
  parameter int DEADLINE_US = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic cancel,
  input  logic ack,
  output logic missed
);
  localparam int DW = $clog2(DEADLINE_US + 1);
  localparam logic [DW-1:0] LIM = DW'(DEADLINE_US);

  logic          running;
  logic [DW-1:0] cnt;
  logic          expire;

  assign expire = running && tick && ((cnt + DW'(1)) >= LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      missed  <= 1'b0;
    end else begin
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (ack || cancel || expire) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (running && tick) begin
        cnt <= cnt + DW'(1);
      end

      if (ack)                  missed <= 1'b0;
      else if (expire && !start) missed <= 1'b1;
    end
  end
endmodule

// File: rtl/hpd_event_top.sv
module hpd_event_top #(
  parameter int CLK_PER_US  = 50,
  parameter int IRQ_MIN_US  = 250,
  parameter int DISC_US     = 2000,
  parameter int DEBOUNCE_US = 100000,
  parameter int DEADLINE_US = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hpd_i,
  input  logic ack_i,
  output logic connect_o,
  output logic disconnect_o,
  output logic irq_o,
  output logic connected_o,
  output logic missed_o
);
  logic line;
  logic tick;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(hpd_i), .dout(line)
  );

  hpd_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  hpd_classifier #(
    .IRQ_MIN_US(IRQ_MIN_US), .DISC_US(DISC_US), .DEBOUNCE_US(DEBOUNCE_US)
  ) u_cls (
    .clk(clk), .rst(rst), .line(line), .tick(tick),
    .connect_o(connect_o), .disconnect_o(disconnect_o),
    .irq_o(irq_o), .connected_o(connected_o)
  );

  hpd_deadline #(.DEADLINE_US(DEADLINE_US)) u_dl (
    .clk(clk), .rst(rst), .tick(tick),
    .start(connect_o | irq_o), .cancel(disconnect_o),
    .ack(ack_i), .missed(missed_o)
  );
endmodule

// File: rtl/hpd_event_chk.sv
module hpd_event_chk (
  input logic clk,
  input logic rst,
  input logic ack_i,
  input logic connect_o,
  input logic disconnect_o,
  input logic irq_o,
  input logic connected_o,
  input logic missed_o
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({connect_o, disconnect_o, irq_o}));

  a_r7_connect_single: assert property (@(posedge clk) disable iff (rst)
    connect_o |=> !connect_o);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r3_rise_has_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(connected_o) |-> connect_o);

  a_r6_drop_has_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(connected_o) |-> disconnect_o);

  a_r6_disc_was_connected: assert property (@(posedge clk) disable iff (rst)
    disconnect_o |-> $past(connected_o));

  a_r5_irq_while_connected: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> connected_o && $past(connected_o));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !missed_o);
endmodule

bind hpd_event_top hpd_event_chk u_chk (
  .clk(clk), .rst(rst), .ack_i(ack_i),
  .connect_o(connect_o), .disconnect_o(disconnect_o), .irq_o(irq_o),
  .connected_o(connected_o), .missed_o(missed_o)
);

// File: tb/hpd_event_top_tb.sv
module hpd_event_top_tb;
  localparam int CPU = 2;
  localparam int MINU = 10;
  localparam int DISU = 40;
  localparam int DBU = 100;
  localparam int DLU = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpd = 1'b0;
  logic ack = 1'b0;
  logic connect_o, disconnect_o, irq_o, connected_o, missed_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  hpd_event_top #(
    .CLK_PER_US(CPU), .IRQ_MIN_US(MINU), .DISC_US(DISU),
    .DEBOUNCE_US(DBU), .DEADLINE_US(DLU), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .hpd_i(hpd), .ack_i(ack),
    .connect_o(connect_o), .disconnect_o(disconnect_o), .irq_o(irq_o),
    .connected_o(connected_o), .missed_o(missed_o)
  );

  // event codes: 1 connect, 2 disconnect, 3 irq
  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_evt(input int code);
    exp_q.push_back(code);
  endtask

  task automatic hold(input logic lvl, input int us);
    @(negedge clk) hpd = lvl;
    repeat (us * CPU - 1) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst) begin
      int got;
      got = 0;
      if ($countones({connect_o, disconnect_o, irq_o}) > 1) check("R7 multi-strobe", 1, 0);
      if (connect_o)    got = 1;
      if (disconnect_o) got = 2;
      if (irq_o)        got = 3;
      if (got != 0) begin
        if (exp_q.size() == 0) check("R4/R7 unexpected event", got, 0);
        else check("R3/R5/R6 event order", got, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 connected after reset", connected_o, 0);
    check("R1 missed after reset", missed_o, 0);
    check("R1 strobes after reset", connect_o | disconnect_o | irq_o, 0);
    rst = 1'b0;

    // R3: broken high window restarts debounce
    hold(1'b1, 60);
    hold(1'b0, 5);
    hold(1'b1, 90);
    check("R3 no connect before full window", connected_o, 0);
    expect_evt(1);
    hold(1'b1, 30);
    check("R3 connected after debounce", connected_o, 1);
    check("R2 event consumed", exp_q.size(), 0);
    pulse_ack();

    // R4: glitch ignored
    hold(1'b0, 3);
    hold(1'b1, 20);
    check("R4 glitch keeps connected", connected_o, 1);

    // R5 + R8: irq without ack -> miss
    expect_evt(3);
    hold(1'b0, 20);
    hold(1'b1, 20);
    check("R5 irq keeps connected", connected_o, 1);
    check("R5 irq seen", exp_q.size(), 0);
    check("R8 no miss yet", missed_o, 0);
    hold(1'b1, 330);
    check("R8 miss after deadline", missed_o, 1);
    pulse_ack();
    @(negedge clk);
    check("R9 ack clears miss", missed_o, 0);

    // R6: long low -> disconnect, then re-plug
    expect_evt(2);
    hold(1'b0, 60);
    check("R6 disconnected", connected_o, 0);
    expect_evt(1);
    hold(1'b1, 120);
    check("R6 re-plug connected", connected_o, 1);
    check("R6 events seen", exp_q.size(), 0);
    pulse_ack();

    // R9: prompt ack prevents miss
    expect_evt(3);
    hold(1'b0, 20);
    hold(1'b1, 50);
    pulse_ack();
    hold(1'b1, 350);
    check("R9 acked irq no miss", missed_o, 0);

    // R10: disconnect cancels pending deadline
    expect_evt(3);
    hold(1'b0, 20);
    hold(1'b1, 20);
    expect_evt(2);
    hold(1'b0, 360);
    check("R10 no miss after disconnect", missed_o, 0);
    check("R10 disconnected", connected_o, 0);
    expect_evt(1);
    hold(1'b1, 120);
    check("R3 final connect", connected_o, 1);
    check("R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule